// File: doc/BRIEF.md
# Power-Fail Chip-Enable Supervisor

This block sits between a host and up to four low-power SRAM banks. While supply power is reported good, it forwards an active-low host chip enable to exactly one of four active-low bank enables, chosen by a two-bit bank select. An external comparator supplies a power-good flag. When that flag drops, the block write-protects every bank and asks the processor to reset.

An access that is already under way when power is lost is allowed to finish. The block then locks all bank enables high. If the host keeps its enable low for longer than a write-protect window, the block drives the enables high anyway. Once power-good returns, a recovery hold keeps the enables inactive and the reset request asserted for a programmable number of clock cycles, whatever the host does during that time.

Both windows are counted in clock cycles. The defaults correspond to about 80 us and 50 ms at 125 MHz. The reset request is an open-drain pull-down enable: a 1 on it means the external reset line is held low. A synchronous reset of the block puts it into the locked state, so a power-up begins with a full recovery hold.

Top module: `pwr_ce_supervisor`

## Requirements
- R1: While `host_ce_n` is 1, all four bits of `bank_ce_n` are 1, whatever `bank_sel` holds.
- R2: While forwarding and `host_ce_n` is 0, `bank_sel` value k (0..3) drives `bank_ce_n[k]` to 0 and the other three bits to 1. At most one bit of `bank_ce_n` is ever 0.
- R3: `pwr_good` passes through a two-flop synchronizer. A change sampled at clock edge n takes effect in the control state at edge n+2.
- R4: Once the block is locked, `bank_ce_n` stays 4'hF for as long as synchronized power-good is low, whatever `host_ce_n` and `bank_sel` do.
- R5: If `host_ce_n` is 0 when the power loss takes effect, the selected bank stays enabled until `host_ce_n` goes high. From the next edge the block is locked.
- R6: If the pending access is still active `WP_CYCLES` edges after entering the pending state, the block locks and all enables go high.
- R7: `rst_pull_low` is 1 in every state except normal forwarding. It is therefore set on the same edge that the power loss takes effect.
- R8: Synchronized power-good must stay high for `REC_CYCLES` consecutive edges while locked. Only then does the block return to forwarding and release `rst_pull_low`. A rise of `pwr_good` set up before edge 1 releases at edge `REC_CYCLES`+2.
- R9: A low on synchronized power-good during the recovery hold clears the hold count. The full `REC_CYCLES` must then elapse again.
- R10: While `rst` is high, the block is locked with `bank_ce_n` = 4'hF and `rst_pull_low` = 1, and the synchronizer reads power as bad. After `rst` falls, the block needs a full recovery hold before it forwards.
- R11: While forwarding, `bank_ce_n` follows `bank_sel` and `host_ce_n` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enters the locked state |
| host_ce_n | input | 1 | Active-low chip enable from the host |
| bank_sel | input | 2 | Bank select for the 2-to-4 decode |
| pwr_good | input | 1 | Asynchronous power-good flag from the external comparator |
| bank_ce_n | output | 4 | Active-low conditioned enables, one per bank |
| rst_pull_low | output | 1 | 1 = pull the open-drain processor reset line low |

## Verification
The hardest situation to reach from the ports is a short power-good glitch in the middle of a recovery hold. The glitch must clear the hold count, and the release must then come a full hold later rather than at the originally due edge. The stimulus drops `pwr_good` for a single cycle partway through the hold, which reaches the control logic as a one-cycle low after the synchronizer. The release edge is then checked against a count taken from the restore, and the edge just before it is also checked. The forced timeout of a stuck access is reached in a similar way: the host enable is held low across the whole write-protect window, and the bank enable is checked on the edge before the deadline and on the deadline edge.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_LOCK  = 2'd2
  } sup_state_t;
endpackage

// File: rtl/pfs_pgood_sync.sv
module pfs_pgood_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pfs_decode.sv
module pfs_decode #(
  parameter int SEL_W = 2,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             fwd_en,
  input  logic             host_ce_n,
  input  logic [SEL_W-1:0] sel,
  output logic [NOUT-1:0]  out_n
);
  for (genvar i = 0; i < NOUT; i++) begin : g_line
    assign out_n[i] = !(fwd_en && !host_ce_n && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
  import pfs_pkg::*;
#(
  parameter int WP_CYCLES  = 10000,
  parameter int REC_CYCLES = 6250000,
  localparam int CNT_MAX = (WP_CYCLES > REC_CYCLES) ? WP_CYCLES : REC_CYCLES,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_s,
  input  logic       host_ce_n,
  output sup_state_t state,
  output logic       fwd_en,
  output logic       rst_pull_low
);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOCK;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          cnt <= '0;
          if (!pg_s) state <= host_ce_n ? ST_LOCK : ST_DRAIN;
        end
        ST_DRAIN: begin
          if (host_ce_n || cnt == WP_LAST) begin
            state <= ST_LOCK;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOCK: begin
          if (!pg_s) begin
            cnt <= '0;
          end else if (cnt == REC_LAST) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_LOCK;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign fwd_en       = (state == ST_RUN) || (state == ST_DRAIN);
  assign rst_pull_low = (state != ST_RUN);

  // R4: a lock with power still bad cannot be left
  assert_lock_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !pg_s) |=> (state == ST_LOCK));

  // R5: loss of power with no access pending goes straight to lock
  assert_idle_fail_locks_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !pg_s && host_ce_n) |=> (state == ST_LOCK));

  // R6: the drain window cannot overrun its deadline
  assert_drain_deadline_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && cnt == WP_LAST) |=> (state == ST_LOCK));

  // R8: forwarding resumes only after a complete recovery count
  assert_release_after_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) == ST_LOCK) |-> ($past(cnt) == REC_LAST && $past(pg_s)));

  // R9: a bad-power cycle in lock restarts the hold from zero
  assert_hold_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !pg_s) |=> (cnt == '0));
endmodule

// File: rtl/pwr_ce_supervisor.sv
module pwr_ce_supervisor
  import pfs_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int WP_CYCLES  = 10000,
  parameter int REC_CYCLES = 6250000,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_ce_n,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic             pwr_good,
  output logic [NOUT-1:0]  bank_ce_n,
  output logic             rst_pull_low
);
  logic       pg_s;
  logic       fwd_en;
  sup_state_t state;

  pfs_pgood_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pwr_good),
    .sync_out (pg_s)
  );

  pfs_ctrl #(.WP_CYCLES(WP_CYCLES), .REC_CYCLES(REC_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .pg_s         (pg_s),
    .host_ce_n    (host_ce_n),
    .state        (state),
    .fwd_en       (fwd_en),
    .rst_pull_low (rst_pull_low)
  );

  pfs_decode #(.SEL_W(SEL_W)) u_dec (
    .fwd_en    (fwd_en),
    .host_ce_n (host_ce_n),
    .sel       (bank_sel),
    .out_n     (bank_ce_n)
  );

  // R2: never more than one bank enabled
  assert_single_bank_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bank_ce_n));

  // R4: a locked controller leaves every bank disabled
  assert_lock_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |-> (bank_ce_n == '1));

  // R1: an idle host enables no bank
  assert_idle_host_R1: assert property (@(posedge clk) disable iff (rst)
    host_ce_n |-> (bank_ce_n == '1));

  // R7: any enabled bank outside normal running sits in the drain window, reset asserted
  assert_reset_in_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (bank_ce_n != '1 && state != ST_RUN) |-> rst_pull_low);
endmodule

// File: tb/pwr_ce_supervisor_test.sv
module pwr_ce_supervisor_test;
  localparam int WP  = 20;
  localparam int REC = 50;

  logic       clk = 1'b0;
  logic       rst;
  logic       host_ce_n;
  logic [1:0] bank_sel;
  logic       pwr_good;
  logic [3:0] bank_ce_n;
  logic       rst_pull_low;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  pwr_ce_supervisor #(.SEL_W(2), .WP_CYCLES(WP), .REC_CYCLES(REC)) uut (
    .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .bank_sel(bank_sel),
    .pwr_good(pwr_good), .bank_ce_n(bank_ce_n), .rst_pull_low(rst_pull_low)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_rst, input logic [3:0] exp_ce);
    n_checks++;
    if (rst_pull_low !== exp_rst || bank_ce_n !== exp_ce) begin
      n_fails++;
      $display("FAIL %s: actual rst=%b ce=%b expected rst=%b ce=%b",
               req, rst_pull_low, bank_ce_n, exp_rst, exp_ce);
    end
  endtask

  function automatic logic [3:0] dec(input logic [1:0] s);
    return ~(4'b0001 << s);
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // drop power with the host idle and wait until lock takes effect (R3, R7)
  task automatic fail_idle;
    host_ce_n = 1'b1;
    pwr_good  = 1'b0;
    tick(2);
    check("R3 still running two edges after drop", 1'b0, 4'hF);
    tick(1);
    check("R7 reset asserted on third edge", 1'b1, 4'hF);
  endtask

  // restore power and check the exact release edge (R8)
  task automatic recover(input logic [1:0] s);
    host_ce_n = 1'b0;
    bank_sel  = s;
    pwr_good  = 1'b1;
    tick(1 + REC);
    check("R8 held one edge before release", 1'b1, 4'hF);
    tick(1);
    check("R8 released after full hold", 1'b0, dec(s));
    host_ce_n = 1'b1;
  endtask

  task automatic t_reset;
    rst = 1'b1; pwr_good = 1'b1; host_ce_n = 1'b0; bank_sel = 2'd0;
    tick(2);
    check("R10 locked during reset", 1'b1, 4'hF);
    rst = 1'b0;
    tick(1 + REC);
    check("R10 full hold after reset", 1'b1, 4'hF);
    tick(1);
    check("R10 forwarding after reset hold", 1'b0, 4'b1110);
    host_ce_n = 1'b1;
    tick(1);
  endtask

  task automatic t_decode;
    for (int k = 0; k < 4; k++) begin
      bank_sel = 2'(k); host_ce_n = 1'b1;
      #1 check("R1 idle host", 1'b0, 4'hF);
      host_ce_n = 1'b0;
      #1 check("R2 decode select", 1'b0, dec(2'(k)));
      tick(1);
      check("R2 decode after edge", 1'b0, dec(2'(k)));
    end
    bank_sel = 2'd1;
    #1 check("R11 select change without edge", 1'b0, 4'b1101);
    host_ce_n = 1'b1;
    tick(1);
  endtask

  task automatic t_fail_idle;
    fail_idle();
    host_ce_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bank_sel = 2'(k);
      tick(1);
      check("R4 locked ignores host", 1'b1, 4'hF);
    end
    recover(2'd2);
  endtask

  task automatic t_fail_access_end;
    host_ce_n = 1'b0; bank_sel = 2'd2; pwr_good = 1'b0;
    tick(3);
    check("R5 access continues in drain", 1'b1, 4'b1011);
    tick(5);
    check("R5 access still continues", 1'b1, 4'b1011);
    host_ce_n = 1'b1;
    #1 check("R5 access ended", 1'b1, 4'hF);
    tick(1);
    host_ce_n = 1'b0;
    #1 check("R5 locked after access end", 1'b1, 4'hF);
    tick(3);
    check("R4 lock persists", 1'b1, 4'hF);
    recover(2'd1);
  endtask

  task automatic t_fail_timeout;
    host_ce_n = 1'b0; bank_sel = 2'd3; pwr_good = 1'b0;
    tick(2 + WP);
    check("R6 access active before deadline", 1'b1, 4'b0111);
    tick(1);
    check("R6 forced off at deadline", 1'b1, 4'hF);
    recover(2'd3);
  endtask

  task automatic t_recover_restart;
    fail_idle();
    host_ce_n = 1'b0; bank_sel = 2'd0; pwr_good = 1'b1;
    tick(20);
    pwr_good = 1'b0;
    tick(1);
    pwr_good = 1'b1;
    tick(1 + REC);
    check("R9 hold restarted after glitch", 1'b1, 4'hF);
    tick(1);
    check("R9 release after restarted hold", 1'b0, 4'b1110);
    host_ce_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_fail_idle();
    t_fail_access_end();
    t_fail_timeout();
    t_recover_restart();
    report();
    $finish;
  end
endmodule